// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Controller

This block watches the input pins of a general-purpose I/O port and raises one interrupt line when an enabled input pin shows a qualifying mismatch. For each pin a mode bit picks the reference. One setting compares the pin with its value in the previous cycle, which detects a change. The other compares it with a programmed default, which detects a level that differs from that default. The port pins pass through a two-flop synchronizer before any comparison is made.

On the first qualifying event the whole synchronized port value is stored in a capture register and the interrupt goes active. Both stay frozen until a read of the chosen register completes. A configuration bit chooses whether that register is the capture register or the live port register. If a qualifying mismatch still exists when the clear arrives, the interrupt stays active and the capture register is reloaded. The interrupt pin can be driven active-low, driven active-high, or used as an open-drain output (an output enable plus a low value).

The block sits behind a decoded register interface. It has a write strobe, and a read-complete strobe that pulses once after the last data bit of a read has been shifted out.

Top module: `gpio_ioc_ctrl`

## Requirements
- R1: A pin can cause an interrupt only if its bit is 1 in both the direction register (address 0, 1 = input) and the enable register (address 1). Activity on any other pin leaves the interrupt inactive.
- R2: Each bit of the mode register (address 2) selects the comparison for its pin. At 0 the synchronized pin is compared with its value one cycle earlier. At 1 it is compared with the same bit of the default register (address 3).
- R3: On a qualifying mismatch while the interrupt is inactive, the synchronized port value is stored in the capture register (read at address 5) and the interrupt goes active. This happens on the third rising clock edge after the port input changes.
- R4: While the interrupt is active, further mismatches neither change the capture register nor start a new event.
- R5: Bit 0 of the configuration register (address 4) selects the clear source. At 1, a read-complete strobe at address 5 (capture) clears the interrupt. At 0, a read-complete strobe at address 6 (port) clears it. A read-complete strobe at the other address has no effect.
- R6: Writes to address 5 or address 6 change neither the interrupt state nor the capture register.
- R7: If a qualifying mismatch exists in the cycle the clear takes effect, the interrupt stays active and the capture register is reloaded with the current synchronized port value. This holds under both clear-source settings.
- R8: Output drive follows configuration bits 2 and 1. With bit 2 = 1 (open-drain), irq_oe equals the active state and irq_o is 0. With bit 2 = 0, irq_oe is 1 and irq_o is the active state when bit 1 = 1 (active-high), or its inverse when bit 1 = 0 (active-low).
- R9: After reset all registers read 0, the interrupt is inactive, irq_o is 1 and irq_oe is 1, and no change is reported for the first sampled port values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_i | input | 8 | Raw port pin levels |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd_done | input | 1 | Read-complete strobe for the register at reg_addr |
| reg_rdata | output | 8 | Read data of the register at reg_addr |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with its default 8-pin width. At that width each pin can be given its own direction, enable and mode bit, and bit patterns can be chosen so that a frozen capture value never equals the live port value. This makes freezing and reloading visible through the capture readout. The bench walks all three output drive modes while the interrupt is active and while it is inactive. It covers re-assertion from a pending default mismatch under both clear sources, and reads of the register that is not selected as the clear source.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR  = 3'd0,
    A_EN   = 3'd1,
    A_MODE = 3'd2,
    A_REF  = 3'd3,
    A_CFG  = 3'd4,
    A_CAP  = 3'd5,
    A_PORT = 3'd6
  } ioc_addr_e;

  localparam int CFG_W        = 3;
  localparam int CFG_CLR_CAP  = 0;
  localparam int CFG_POL_HIGH = 1;
  localparam int CFG_OPEN_DR  = 2;
endpackage

// File: rtl/ioc_regs.sv
module ioc_regs
  import gpio_ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      cap_i,
  input  logic [W-1:0]      port_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      en_o,
  output logic [W-1:0]      mode_o,
  output logic [W-1:0]      ref_o,
  output logic [CFG_W-1:0]  cfg_o
);
  logic [W-1:0]     dir_q, en_q, mode_q, ref_q;
  logic [W-1:0]     dir_d, en_d, mode_d, ref_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    dir_d  = dir_q;
    en_d   = en_q;
    mode_d = mode_q;
    ref_d  = ref_q;
    cfg_d  = cfg_q;
    if (wr_i) begin
      case (addr_i)
        A_DIR:   dir_d  = wdata_i;
        A_EN:    en_d   = wdata_i;
        A_MODE:  mode_d = wdata_i;
        A_REF:   ref_d  = wdata_i;
        A_CFG:   cfg_d  = wdata_i[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      en_q   <= '0;
      mode_q <= '0;
      ref_q  <= '0;
      cfg_q  <= '0;
    end else if (wr_i) begin
      dir_q  <= dir_d;
      en_q   <= en_d;
      mode_q <= mode_d;
      ref_q  <= ref_d;
      cfg_q  <= cfg_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DIR:   rdata_o = dir_q;
      A_EN:    rdata_o = en_q;
      A_MODE:  rdata_o = mode_q;
      A_REF:   rdata_o = ref_q;
      A_CFG:   rdata_o = W'(cfg_q);
      A_CAP:   rdata_o = cap_i;
      A_PORT:  rdata_o = port_i;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign ref_o  = ref_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int W         = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] ref_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] hit_o
);
  localparam int PRIME_CYC = SYNC_LEN + 1;
  localparam int PC_W      = $clog2(PRIME_CYC + 1);

  logic [W-1:0]    stage_q [SYNC_LEN];
  logic [W-1:0]    prev_q;
  logic [PC_W-1:0] prime_q, prime_d;
  logic            primed;

  genvar gs;
  generate
    for (gs = 0; gs < SYNC_LEN; gs++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gs] <= '0;
        else if (gs == 0) stage_q[gs] <= pin_i;
        else stage_q[gs] <= stage_q[gs-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[SYNC_LEN-1];
  assign primed = (prime_q == PC_W'(PRIME_CYC));

  always_comb begin
    prime_d = primed ? prime_q : prime_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q <= '0;
      prev_q  <= '0;
    end else begin
      prime_q <= prime_d;
      prev_q  <= sync_o;
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < W; gp++) begin : g_pin
      logic diff;
      assign diff      = mode_i[gp] ? (sync_o[gp] ^ ref_i[gp]) : (sync_o[gp] ^ prev_q[gp]);
      assign hit_o[gp] = primed & dir_i[gp] & en_i[gp] & diff;
    end
  endgenerate

  assert_pin_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~(dir_i & en_i)) == '0);
endmodule

// File: rtl/ioc_capture.sv
module ioc_capture
  import gpio_ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      sync_i,
  input  logic [W-1:0]      hit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_done_i,
  input  logic              clr_cap_i,
  output logic              active_o,
  output logic [W-1:0]      cap_o
);
  logic         active_q, active_d;
  logic [W-1:0] cap_q, cap_d;
  logic         clr, any_hit, cap_en;
  ioc_addr_e    clr_addr;

  assign clr_addr = clr_cap_i ? A_CAP : A_PORT;
  assign clr      = rd_done_i && (addr_i == clr_addr);
  assign any_hit  = |hit_i;
  assign cap_en   = any_hit && (!active_q || clr);

  always_comb begin
    active_d = active_q;
    cap_d    = cap_q;
    if (cap_en) begin
      active_d = 1'b1;
      cap_d    = sync_i;
    end else if (clr) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cap_q    <= '0;
    end else begin
      active_q <= active_d;
      if (cap_en) cap_q <= cap_d;
    end
  end

  assign active_o = active_q;
  assign cap_o    = cap_q;

  assert_first_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && any_hit) |=> (active_q && cap_q == $past(sync_i)));

  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !clr) |=> (active_q && $stable(cap_q)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && clr && !any_hit) |=> !active_q);

  assert_refire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && any_hit) |=> (active_q && cap_q == $past(sync_i)));
endmodule

// File: rtl/ioc_drive.sv
module ioc_drive (
  input  logic active_i,
  input  logic pol_high_i,
  input  logic open_drain_i,
  output logic irq_o,
  output logic irq_oe
);
  always_comb begin
    if (open_drain_i) begin
      irq_oe = active_i;
      irq_o  = 1'b0;
    end else begin
      irq_oe = 1'b1;
      irq_o  = pol_high_i ? active_i : ~active_i;
    end
  end

  always_comb begin
    assert_od_low_R8: assert (!(open_drain_i && irq_oe && irq_o));
  end
endmodule

// File: rtl/gpio_ioc_ctrl.sv
module gpio_ioc_ctrl
  import gpio_ioc_pkg::*;
#(
  parameter int W        = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      port_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [W-1:0]      reg_wdata,
  input  logic              reg_rd_done,
  output logic [W-1:0]      reg_rdata,
  output logic              irq_o,
  output logic              irq_oe
);
  logic             rst_meta_q, rst_sync_n;
  logic [W-1:0]     dir, en, mode, refv, sync, hit, cap;
  logic [CFG_W-1:0] cfg;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ioc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr_i(reg_addr), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .cap_i(cap), .port_i(sync), .rdata_o(reg_rdata),
    .dir_o(dir), .en_o(en), .mode_o(mode), .ref_o(refv), .cfg_o(cfg)
  );

  ioc_detect #(.W(W), .SYNC_LEN(SYNC_LEN)) u_detect (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(port_i), .dir_i(dir), .en_i(en),
    .mode_i(mode), .ref_i(refv), .sync_o(sync), .hit_o(hit)
  );

  ioc_capture #(.W(W)) u_capture (
    .clk(clk), .rst_n(rst_sync_n), .sync_i(sync), .hit_i(hit),
    .addr_i(reg_addr), .rd_done_i(reg_rd_done), .clr_cap_i(cfg[CFG_CLR_CAP]),
    .active_o(active), .cap_o(cap)
  );

  ioc_drive u_drive (
    .active_i(active), .pol_high_i(cfg[CFG_POL_HIGH]),
    .open_drain_i(cfg[CFG_OPEN_DR]), .irq_o(irq_o), .irq_oe(irq_oe)
  );
endmodule

// File: tb/gpio_ioc_ctrl_bench.sv
module gpio_ioc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port_i = 8'h00;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_rd_done = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_o, irq_oe;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_ioc_ctrl u_gpio_ioc_ctrl (
    .clk(clk), .rst_n(rst_n), .port_i(port_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd_done(reg_rd_done),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_done(logic [2:0] a);
    @(negedge clk);
    reg_addr = a; reg_rd_done = 1'b1;
    @(negedge clk);
    reg_rd_done = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_port(logic [7:0] v);
    @(negedge clk);
    port_i = v;
    repeat (4) @(negedge clk);
  endtask

  // irq state in active-low push-pull mode: pin 0 means active
  task automatic chk_irq(string req, logic exp_active);
    check(req, {7'd0, irq_o}, {7'd0, ~exp_active});
  endtask

  task automatic chk_cap(string req, logic [7:0] exp);
    logic [7:0] d;
    rd(3'd5, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R9 irq_o", {7'd0, irq_o}, 8'h01);
    check("R9 irq_oe", {7'd0, irq_oe}, 8'h01);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R9 reg zero", d, 8'h00);
    end
  endtask

  task automatic t_change_and_freeze();
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'h00); wr(3'd4, 8'h01);
    set_port(8'h00);
    chk_irq("R9 no spurious", 1'b0);
    set_port(8'h05);
    chk_irq("R3 active", 1'b1);
    chk_cap("R3 capture", 8'h05);
    set_port(8'h0F);
    chk_irq("R4 still active", 1'b1);
    chk_cap("R4 frozen", 8'h05);
  endtask

  task automatic t_ignore_and_clear();
    wr(3'd5, 8'hAA); wr(3'd6, 8'h55);
    chk_irq("R6 write no clear", 1'b1);
    chk_cap("R6 write no capture", 8'h05);
    rd_done(3'd6);
    chk_irq("R5 port read ignored when cap selected", 1'b1);
    rd_done(3'd5);
    @(negedge clk);
    chk_irq("R5 cap read clears", 1'b0);
  endtask

  task automatic t_qualify();
    wr(3'd0, 8'h7F);
    set_port(8'h8F);
    chk_irq("R1 output pin ignored", 1'b0);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFE);
    set_port(8'h8E);
    chk_irq("R1 disabled pin ignored", 1'b0);
    wr(3'd1, 8'hFF);
  endtask

  task automatic t_default_refire_cap();
    wr(3'd3, 8'h8E); wr(3'd2, 8'hFF);
    repeat (2) @(negedge clk);
    chk_irq("R2 equal default no irq", 1'b0);
    set_port(8'h8C);
    chk_irq("R2 default mismatch", 1'b1);
    chk_cap("R2 capture", 8'h8C);
    set_port(8'h88);
    chk_cap("R4 frozen default", 8'h8C);
    rd_done(3'd5);
    @(negedge clk);
    chk_irq("R7 refire cfg1", 1'b1);
    chk_cap("R7 reload cfg1", 8'h88);
    set_port(8'h8E);
    chk_irq("R4 match while active", 1'b1);
    rd_done(3'd5);
    @(negedge clk);
    chk_irq("R5 clear after match", 1'b0);
  endtask

  task automatic t_default_refire_port();
    wr(3'd4, 8'h00);
    set_port(8'h9E);
    chk_irq("R2 active cfg0", 1'b1);
    chk_cap("R3 capture cfg0", 8'h9E);
    set_port(8'hBE);
    rd_done(3'd5);
    chk_irq("R5 cap read ignored when port selected", 1'b1);
    chk_cap("R4 frozen cfg0", 8'h9E);
    rd_done(3'd6);
    @(negedge clk);
    chk_irq("R7 refire cfg0", 1'b1);
    chk_cap("R7 reload cfg0", 8'hBE);
  endtask

  task automatic t_modes();
    wr(3'd4, 8'h02);
    check("R8 high active o", {7'd0, irq_o}, 8'h01);
    check("R8 high active oe", {7'd0, irq_oe}, 8'h01);
    wr(3'd4, 8'h04);
    check("R8 od active o", {7'd0, irq_o}, 8'h00);
    check("R8 od active oe", {7'd0, irq_oe}, 8'h01);
    set_port(8'h8E);
    rd_done(3'd6);
    @(negedge clk);
    check("R8 od idle oe", {7'd0, irq_oe}, 8'h00);
    wr(3'd4, 8'h02);
    check("R8 high idle o", {7'd0, irq_o}, 8'h00);
    check("R8 high idle oe", {7'd0, irq_oe}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    t_reset();
    t_change_and_freeze();
    t_ignore_and_clear();
    t_qualify();
    t_default_refire_cap();
    t_default_refire_port();
    t_modes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule